// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the bytes that follow a start or repeated start on an I2C bus address this device. A bit-level receiver in front of it supplies whole bytes with a one-cycle valid strobe, plus a one-cycle pulse for each start or repeated start. Software-visible configuration enters as plain inputs: a low address field, a three-bit high address field, a mode bit for 10-bit addressing and an enable for general call recognition.

After the header byte or bytes of a transaction, the block raises a match flag and reports the transfer direction. If the header was the general call, it also raises a separate flag. These results stay unchanged through the data phase until the next start. The block does not handle bit timing, acknowledge driving or clock stretching.

Top module: `i2c_addr_match`

## Requirements
- R1: After synchronous reset, `match_o`, `gcall_o` and `rd_o` are 0. Every result of a transaction appears on the clock edge that samples its deciding byte strobe, so it is visible in the cycle after the strobe.
- R2: With `ext_en_i`=0, the first byte after a start matches when its bits 7..1 equal `addr_lo_i[6:0]`. `rd_o` then takes byte bit 0 (1 = read), and `gcall_o` stays 0. Any other byte gives no match.
- R3: With `gc_en_i`=1, a first byte of 0x00 sets both `match_o` and `gcall_o`, with `rd_o`=0. This holds in either addressing mode.
- R4: With `gc_en_i`=0, a first byte of 0x00 never sets `gcall_o`. For an own address other than zero, it sets no match.
- R5: With `ext_en_i`=1, a first byte of binary 11110, `addr_hi_i[1:0]`, 0 gives no match by itself. A second byte equal to `addr_lo_i[7:0]` then sets `match_o` with `rd_o`=0. Any other second byte, or any other first byte, gives no match.
- R6: With `ext_en_i`=1, a first byte of binary 11110, `addr_hi_i[1:0]`, 1 sets `match_o` with `rd_o`=1 at once. This happens only if the most recent completed 10-bit header was a full write match. Otherwise it gives no match.
- R7: A start pulse clears all three outputs on the next edge. A byte strobe in the same cycle as a start is ignored.
- R8: Bytes after the header, and bytes before any start, leave the outputs unchanged.
- R9: `addr_hi_i[2]` has no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated start pulse |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| addr_lo_i | input | 8 | Own address low bits (7-bit mode uses [6:0]) |
| addr_hi_i | input | 3 | Own address high bits (bits 1..0 are address bits 9..8) |
| ext_en_i | input | 1 | 1 = 10-bit addressing |
| gc_en_i | input | 1 | 1 = general call recognised |
| match_o | output | 1 | Device addressed |
| gcall_o | output | 1 | General call received |
| rd_o | output | 1 | Direction of the addressed transfer, 1 = read |

## Verification
A wrong header state shows up one cycle after the next byte strobe. A stuck second-byte wait holds back a match. A lost 10-bit history bit makes a read re-address fail, or succeed when it should not, on the first header after a repeated start. A reference model compares every output on every cycle, so such a fault is reported within one cycle of the byte that exposes it.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    localparam int BYTE_W = 8;
    localparam int LO_W   = 8;
    localparam int HI_W   = 3;
    localparam int A7_W   = 7;
    localparam logic [4:0]        TEN_PREFIX = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_CODE    = '0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR1 = 2'd1,
        ST_HDR2 = 2'd2
    } am_state_e;

    typedef struct packed {
        logic gc;     // byte is the general call code and it is enabled
        logic addr7;  // 7-bit mode and bits 7..1 match
        logic hdr10;  // 10-bit mode and header prefix plus high bits match
        logic lo10;   // 10-bit mode and byte equals low address
    } am_hits_t;

    function automatic logic hdr10_ok(input logic [BYTE_W-1:0] b,
                                      input logic [1:0] hi);
        return (b[7:3] == TEN_PREFIX) && (b[2:1] == hi);
    endfunction
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [LO_W-1:0]   addr_lo_i,
    input  logic [HI_W-1:0]   addr_hi_i,
    input  logic              ext_en_i,
    input  logic              gc_en_i,
    output am_hits_t          hits_o
);
    always_comb begin
        hits_o.gc    = gc_en_i && (byte_i == GC_CODE);
        hits_o.addr7 = !ext_en_i && (byte_i[BYTE_W-1:1] == addr_lo_i[A7_W-1:0]);
        hits_o.hdr10 = ext_en_i && hdr10_ok(byte_i, addr_hi_i[1:0]);
        hits_o.lo10  = ext_en_i && (byte_i == addr_lo_i);
    end
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     byte_vld_i,
    input  logic     rw_bit_i,
    input  am_hits_t hits_i,
    output logic     match_o,
    output logic     gcall_o,
    output logic     rd_o
);
    am_state_e state;
    logic      prev10;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            match_o <= 1'b0;
            gcall_o <= 1'b0;
            rd_o    <= 1'b0;
            prev10  <= 1'b0;
        end else if (start_i) begin
            state   <= ST_HDR1;
            match_o <= 1'b0;
            gcall_o <= 1'b0;
            rd_o    <= 1'b0;
        end else if (byte_vld_i) begin
            case (state)
                ST_HDR1: begin
                    state <= ST_IDLE;
                    if (hits_i.gc) begin
                        match_o <= 1'b1;
                        gcall_o <= 1'b1;
                        rd_o    <= 1'b0;
                        prev10  <= 1'b0;
                    end else if (hits_i.addr7) begin
                        match_o <= 1'b1;
                        rd_o    <= rw_bit_i;
                        prev10  <= 1'b0;
                    end else if (hits_i.hdr10 && !rw_bit_i) begin
                        state <= ST_HDR2;
                    end else if (hits_i.hdr10 && prev10) begin
                        match_o <= 1'b1;
                        rd_o    <= 1'b1;
                    end else begin
                        prev10 <= 1'b0;
                    end
                end
                ST_HDR2: begin
                    state <= ST_IDLE;
                    if (hits_i.lo10) begin
                        match_o <= 1'b1;
                        rd_o    <= 1'b0;
                        prev10  <= 1'b1;
                    end else begin
                        prev10 <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [LO_W-1:0]   addr_lo_i,
    input  logic [HI_W-1:0]   addr_hi_i,
    input  logic              ext_en_i,
    input  logic              gc_en_i,
    output logic              match_o,
    output logic              gcall_o,
    output logic              rd_o
);
    am_hits_t hits;

    i2c_am_cmp u_cmp (
        .byte_i    (byte_i),
        .addr_lo_i (addr_lo_i),
        .addr_hi_i (addr_hi_i),
        .ext_en_i  (ext_en_i),
        .gc_en_i   (gc_en_i),
        .hits_o    (hits)
    );

    i2c_am_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .byte_vld_i (byte_vld_i),
        .rw_bit_i   (byte_i[0]),
        .hits_i     (hits),
        .match_o    (match_o),
        .gcall_o    (gcall_o),
        .rd_o       (rd_o)
    );
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       byte_vld_i,
    input logic [7:0] byte_i,
    input logic       gc_en_i,
    input logic       match_o,
    input logic       gcall_o,
    input logic       rd_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!match_o && !gcall_o && !rd_o)); // R1

    AST_GC_IMPLIES_MATCH: assert property (@(posedge clk) disable iff (rst)
        gcall_o |-> (match_o && !rd_o)); // R3

    AST_GC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(gcall_o) |-> ($past(gc_en_i) && $past(byte_i) == 8'h00)); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!match_o && !gcall_o && !rd_o)); // R7

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !byte_vld_i) |=> ($stable(match_o) && $stable(gcall_o) && $stable(rd_o))); // R8
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .gc_en_i    (gc_en_i),
    .match_o    (match_o),
    .gcall_o    (gcall_o),
    .rd_o       (rd_o)
);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00, addr_lo_i = 8'h00;
    logic [2:0] addr_hi_i = 3'b000;
    logic ext_en_i = 1'b0, gc_en_i = 1'b0;
    logic match_o, gcall_o, rd_o;

    int n_chk = 0, n_fail = 0, cycles = 0;
    string cur_req = "R1";

    // reference model state
    int  m_phase = 0;          // 0 idle, 1 expect first byte, 2 expect second byte
    bit  m_hist = 0;
    bit  e_m = 0, e_g = 0, e_r = 0;

    always #10 clk = ~clk;

    i2c_addr_match dut (.*);

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0; m_hist = 0; e_m = 0; e_g = 0; e_r = 0;
        end else if (start_i) begin
            m_phase = 1; e_m = 0; e_g = 0; e_r = 0;
        end else if (byte_vld_i && m_phase == 1) begin
            m_phase = 0;
            if (gc_en_i && byte_i == 0) begin
                e_m = 1; e_g = 1; e_r = 0; m_hist = 0;
            end else if (!ext_en_i) begin
                if (byte_i[7:1] == addr_lo_i[6:0]) begin e_m = 1; e_r = byte_i[0]; end
                m_hist = 0;
            end else if (byte_i[7:3] == 5'd30 && byte_i[2:1] == addr_hi_i[1:0]) begin
                if (byte_i[0] == 0) m_phase = 2;
                else if (m_hist) begin e_m = 1; e_r = 1; end
            end else m_hist = 0;
        end else if (byte_vld_i && m_phase == 2) begin
            m_phase = 0;
            if (byte_i == addr_lo_i) begin e_m = 1; e_r = 0; m_hist = 1; end
            else m_hist = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_chk++;
            if ({match_o, gcall_o, rd_o} !== {e_m, e_g, e_r}) begin
                n_fail++;
                $display("FAIL %s model: got m%b g%b r%b exp m%b g%b r%b",
                         cur_req, match_o, gcall_o, rd_o, e_m, e_g, e_r);
            end
        end
        if (cycles > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic expect3(string req, bit m, bit g, bit r);
        n_chk++;
        if ({match_o, gcall_o, rd_o} !== {m, g, r}) begin
            n_fail++;
            $display("FAIL %s: got m%b g%b r%b exp m%b g%b r%b", req,
                     match_o, gcall_o, rd_o, m, g, r);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        byte_vld_i = 1'b1; byte_i = b; @(negedge clk); byte_vld_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect3("R1", 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        expect3("R1", 0, 0, 0);

        cur_req = "R8"; addr_lo_i = 8'h5A;
        send(8'hB4); expect3("R8", 0, 0, 0);         // no start yet

        cur_req = "R2";
        do_start(); send(8'hB4); expect3("R2", 1, 0, 0);
        cur_req = "R8";
        send(8'h00); send(8'hFF); expect3("R8", 1, 0, 0);
        cur_req = "R7";
        do_start(); expect3("R7", 0, 0, 0);
        cur_req = "R2";
        send(8'hB5); expect3("R2", 1, 0, 1);
        do_start(); send(8'hB6); expect3("R2", 0, 0, 0);

        cur_req = "R3"; gc_en_i = 1'b1;
        do_start(); send(8'h00); expect3("R3", 1, 1, 0);
        cur_req = "R4"; gc_en_i = 1'b0;
        do_start(); send(8'h00); expect3("R4", 0, 0, 0);

        cur_req = "R7";
        byte_vld_i = 1'b1; byte_i = 8'hB4; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; byte_vld_i = 1'b0;
        expect3("R7", 0, 0, 0);
        send(8'hB4); expect3("R7", 1, 0, 0);

        cur_req = "R5"; ext_en_i = 1'b1; addr_hi_i = 3'b110; addr_lo_i = 8'h3C;
        do_start(); send(8'hF4); expect3("R5", 0, 0, 0);
        send(8'h3C); expect3("R5", 1, 0, 0);
        cur_req = "R6";
        do_start(); send(8'hF5); expect3("R6", 1, 0, 1);
        do_start(); send(8'hF5); expect3("R6", 1, 0, 1);
        cur_req = "R5";
        do_start(); send(8'hF4); send(8'h3D); expect3("R5", 0, 0, 0);
        cur_req = "R6";
        do_start(); send(8'hF5); expect3("R6", 0, 0, 0);
        cur_req = "R5";
        do_start(); send(8'hF2); send(8'h3C); expect3("R5", 0, 0, 0);

        cur_req = "R9"; addr_hi_i = 3'b010;
        do_start(); send(8'hF4); send(8'h3C); expect3("R9", 1, 0, 0);
        do_start(); send(8'hF5); expect3("R9", 1, 0, 1);

        cur_req = "R3"; gc_en_i = 1'b1;
        do_start(); send(8'h00); expect3("R3", 1, 1, 0);
        cur_req = "R6";
        do_start(); send(8'hF5); expect3("R6", 0, 0, 0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule